// File: doc/BRIEF.md
# PCIe Request to Wishbone Master Bridge

This block sits behind a PCIe transaction-layer receiver and turns each already-parsed single-dword memory request into one Wishbone master cycle. A request carries a direction (write or read), the index of the BAR it hit, a dword offset inside that BAR, byte enables, a tag, a requester ID and, for writes, one dword of data. Writes are posted: they produce a bus cycle and nothing else. Reads are non-posted: the dword returned by the bus cycle is sent back in a completion record that echoes the request's tag and requester ID.

Address translation is done by a purely combinational resource decoder. It is consulted in a control state of its own that sits between accepting a request and starting the bus cycle. BAR 0 is a single window onto one resource. BAR 1 is cut into equal sub-windows, each pointing at a different resource. Anything that decodes to no resource never reaches the bus. A write of that kind is discarded, and a read of that kind is answered with an Unsupported Request completion. Only one request is handled at a time.

Top module: `pcie_wb_bridge`

## Requirements
- R1: While reset is held and directly after it, `req_ready` is 1, `wb_cyc` and `wb_stb` are 0 and `cpl_valid` is 0.
- R2: A request is taken at a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the block is idle again, so only one request is outstanding.
- R3: After a request is taken, one full cycle is spent in address decode. For a hit, `wb_cyc` and `wb_stb` first read 1 after the second rising edge that follows the accepting edge.
- R4: BAR 0 (`req_bar` = 0) is one window of 1024 dwords. A dword offset d maps to byte address `wb_adr` = 4*d.
- R5: BAR 1 (`req_bar` = 1) is split into 64-dword sub-windows, with index k = d[9:6]. For k below 3, `wb_adr` = 0x4000 + k*0x1000 + 4*d[5:0].
- R6: A request to any other BAR, or to BAR 1 with k of 3 or more, starts no Wishbone cycle. Such a write is dropped with no completion, and `req_ready` returns after decode. Such a read yields one completion with `cpl_status` = 3'b001 (Unsupported Request), `cpl_has_data` = 0 and `cpl_data` = 0.
- R7: During a cycle `wb_cyc` and `wb_stb` are both 1, and `wb_adr`, `wb_sel`, `wb_we` and `wb_dat_o` hold steady until `wb_ack`. `wb_we` is 1 only for writes. `wb_sel` equals the request byte enables and `wb_dat_o` equals the write data.
- R8: A write that hits ends at the edge where `wb_ack` is sampled 1. It produces no completion, and `req_ready` is 1 after that edge.
- R9: A read that hits ends at the edge where `wb_ack` is sampled 1. For the cycle that follows, `cpl_valid` is 1 with `cpl_status` = 3'b000 (Successful Completion), `cpl_has_data` = 1, `cpl_data` equal to `wb_dat_i` at that edge, and the request's tag and requester ID. `req_ready` returns one cycle later.
- R10: For a read that misses, the single-cycle completion appears directly after the decode cycle. That is two edges after acceptance, with no bus cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_is_wr | input | 1 | 1 = memory write, 0 = memory read |
| req_bar | input | 3 | Index of the BAR that was hit |
| req_dwa | input | 10 | Dword offset inside the BAR |
| req_be | input | 4 | Byte enables |
| req_tag | input | 8 | Request tag |
| req_rid | input | 16 | Requester ID |
| req_data | input | 32 | Write data |
| wb_cyc | output | 1 | Wishbone cycle |
| wb_stb | output | 1 | Wishbone strobe |
| wb_we | output | 1 | Wishbone write enable |
| wb_adr | output | 16 | Wishbone byte address |
| wb_sel | output | 4 | Wishbone byte selects |
| wb_dat_o | output | 32 | Wishbone write data |
| wb_dat_i | input | 32 | Wishbone read data |
| wb_ack | input | 1 | Wishbone acknowledge |
| cpl_valid | output | 1 | Completion present (one cycle) |
| cpl_status | output | 3 | 000 successful, 001 unsupported request |
| cpl_has_data | output | 1 | Completion carries a data dword |
| cpl_data | output | 32 | Completion payload |
| cpl_tag | output | 8 | Echoed tag |
| cpl_rid | output | 16 | Echoed requester ID |

## Verification
The properties assume that the Wishbone target raises `wb_ack` only while `wb_cyc` is high and for one cycle at a time. Under that assumption, an unacknowledged cycle must keep its address and controls, and a completion can only follow an acknowledged read or a missed decode. The bench model of the target acts only while it sees `wb_cyc`, waits a random number of cycles (zero included), pulses the acknowledge once and then drops it. Requests are presented only while `req_ready` is 1, with BAR indices and offsets drawn at random over both mapped and unmapped ranges, plus directed edge offsets.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECODE = 2'd1,
    ST_WB     = 2'd2,
    ST_CPL    = 2'd3
  } pwb_state_e;

  localparam logic [2:0] CPL_SC = 3'b000;
  localparam logic [2:0] CPL_UR = 3'b001;

  // byte address of a dword offset
  function automatic int unsigned dw_to_byte(input int unsigned dw);
    return dw * 4;
  endfunction

  // base address of sub-window k of the split BAR
  function automatic int unsigned sub_window_base(input int unsigned base,
                                                  input int unsigned stride,
                                                  input int unsigned k);
    return base + k * stride;
  endfunction

endpackage

// File: rtl/pwb_res_decode.sv
module pwb_res_decode #(
  parameter int BAR_W      = 3,
  parameter int DWA_W      = 10,
  parameter int WB_AW      = 16,
  parameter int BAR_SINGLE = 0,
  parameter int BAR_SPLIT  = 1,
  parameter int unsigned SINGLE_BASE = 32'h0000,
  parameter int SUB_DW_LG  = 6,
  parameter int SUB_N      = 3,
  parameter int unsigned SUB_BASE   = 32'h4000,
  parameter int unsigned SUB_STRIDE = 32'h1000
) (
  input  logic [BAR_W-1:0] bar,
  input  logic [DWA_W-1:0] dwa,
  output logic             hit,
  output logic [WB_AW-1:0] adr
);
  import pwb_pkg::*;

  localparam int IDX_W = DWA_W - SUB_DW_LG;

  logic             single_hit;
  logic [WB_AW-1:0] single_adr;
  logic [SUB_N-1:0] sub_hit;
  logic [WB_AW-1:0] sub_adr [SUB_N];

  assign single_hit = (bar == BAR_W'(BAR_SINGLE));
  assign single_adr = WB_AW'(SINGLE_BASE) + WB_AW'(dw_to_byte(32'(dwa)));

  for (genvar k = 0; k < SUB_N; k++) begin : g_sub
    assign sub_hit[k] = (bar == BAR_W'(BAR_SPLIT)) &&
                        (dwa[DWA_W-1:SUB_DW_LG] == IDX_W'(k));
    assign sub_adr[k] = WB_AW'(sub_window_base(SUB_BASE, SUB_STRIDE, k)) +
                        WB_AW'(dw_to_byte(32'(dwa[SUB_DW_LG-1:0])));
  end

  always_comb begin
    hit = single_hit;
    adr = single_hit ? single_adr : '0;
    for (int i = 0; i < SUB_N; i++) begin
      if (sub_hit[i]) begin
        hit = 1'b1;
        adr = adr | sub_adr[i];
      end
    end
  end

endmodule

// File: rtl/pwb_fsm.sv
module pwb_fsm (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                is_wr,
  input  logic                dec_hit,
  input  logic                wb_ack,
  output pwb_pkg::pwb_state_e state,
  output logic                ev_accept,
  output logic                ev_decode,
  output logic                ev_ack
);
  import pwb_pkg::*;

  pwb_state_e nxt;

  assign ev_accept = (state == ST_IDLE) && req_valid;
  assign ev_decode = (state == ST_DECODE);
  assign ev_ack    = (state == ST_WB) && wb_ack;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (req_valid) nxt = ST_DECODE;
      ST_DECODE: begin
        if (dec_hit)     nxt = ST_WB;
        else if (is_wr)  nxt = ST_IDLE;
        else             nxt = ST_CPL;
      end
      ST_WB:     if (wb_ack) nxt = is_wr ? ST_IDLE : ST_CPL;
      ST_CPL:    nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/pwb_datapath.sv
module pwb_datapath #(
  parameter int BAR_W = 3,
  parameter int DWA_W = 10,
  parameter int WB_AW = 16,
  parameter int DW    = 32,
  parameter int TAG_W = 8,
  parameter int RID_W = 16,
  localparam int BE_W = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_accept,
  input  logic             ev_decode,
  input  logic             ev_ack,
  input  logic             req_is_wr,
  input  logic [BAR_W-1:0] req_bar,
  input  logic [DWA_W-1:0] req_dwa,
  input  logic [BE_W-1:0]  req_be,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [RID_W-1:0] req_rid,
  input  logic [DW-1:0]    req_data,
  input  logic             dec_hit,
  input  logic [WB_AW-1:0] dec_adr,
  input  logic [DW-1:0]    wb_dat_i,
  output logic             cap_wr,
  output logic [BAR_W-1:0] cap_bar,
  output logic [DWA_W-1:0] cap_dwa,
  output logic [BE_W-1:0]  cap_be,
  output logic [TAG_W-1:0] cap_tag,
  output logic [RID_W-1:0] cap_rid,
  output logic [DW-1:0]    cap_data,
  output logic [WB_AW-1:0] adr_q,
  output logic [2:0]       status_q,
  output logic             has_data_q,
  output logic [DW-1:0]    rdata_q
);
  import pwb_pkg::*;

  // request capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_wr   <= 1'b0;
      cap_bar  <= '0;
      cap_dwa  <= '0;
      cap_be   <= '0;
      cap_tag  <= '0;
      cap_rid  <= '0;
      cap_data <= '0;
    end else if (ev_accept) begin
      cap_wr   <= req_is_wr;
      cap_bar  <= req_bar;
      cap_dwa  <= req_dwa;
      cap_be   <= req_be;
      cap_tag  <= req_tag;
      cap_rid  <= req_rid;
      cap_data <= req_data;
    end
  end

  // translated address, latched in the decode state
  always_ff @(posedge clk) begin
    if (!rst_n)         adr_q <= '0;
    else if (ev_decode) adr_q <= dec_adr;
  end

  // completion contents
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q   <= CPL_SC;
      has_data_q <= 1'b0;
      rdata_q    <= '0;
    end else if (ev_decode && !dec_hit) begin
      status_q   <= CPL_UR;
      has_data_q <= 1'b0;
      rdata_q    <= '0;
    end else if (ev_ack) begin
      status_q   <= CPL_SC;
      has_data_q <= 1'b1;
      rdata_q    <= wb_dat_i;
    end
  end

endmodule

// File: rtl/pcie_wb_bridge.sv
module pcie_wb_bridge #(
  parameter int BAR_W      = 3,
  parameter int DWA_W      = 10,
  parameter int WB_AW      = 16,
  parameter int DW         = 32,
  parameter int TAG_W      = 8,
  parameter int RID_W      = 16,
  parameter int SUB_DW_LG  = 6,
  parameter int SUB_N      = 3,
  parameter int unsigned SUB_BASE   = 32'h4000,
  parameter int unsigned SUB_STRIDE = 32'h1000,
  localparam int BE_W = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_is_wr,
  input  logic [BAR_W-1:0] req_bar,
  input  logic [DWA_W-1:0] req_dwa,
  input  logic [BE_W-1:0]  req_be,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [RID_W-1:0] req_rid,
  input  logic [DW-1:0]    req_data,
  output logic             wb_cyc,
  output logic             wb_stb,
  output logic             wb_we,
  output logic [WB_AW-1:0] wb_adr,
  output logic [BE_W-1:0]  wb_sel,
  output logic [DW-1:0]    wb_dat_o,
  input  logic [DW-1:0]    wb_dat_i,
  input  logic             wb_ack,
  output logic             cpl_valid,
  output logic [2:0]       cpl_status,
  output logic             cpl_has_data,
  output logic [DW-1:0]    cpl_data,
  output logic [TAG_W-1:0] cpl_tag,
  output logic [RID_W-1:0] cpl_rid
);
  import pwb_pkg::*;

  pwb_state_e       state;
  logic             ev_accept, ev_decode, ev_ack;
  logic             ev_hit;
  logic [WB_AW-1:0] dec_adr;
  logic             cap_wr;
  logic [BAR_W-1:0] cap_bar;
  logic [DWA_W-1:0] cap_dwa;
  logic             in_cycle;

  pwb_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .is_wr     (cap_wr),
    .dec_hit   (ev_hit),
    .wb_ack    (wb_ack),
    .state     (state),
    .ev_accept (ev_accept),
    .ev_decode (ev_decode),
    .ev_ack    (ev_ack)
  );

  pwb_res_decode #(
    .BAR_W      (BAR_W),
    .DWA_W      (DWA_W),
    .WB_AW      (WB_AW),
    .SUB_DW_LG  (SUB_DW_LG),
    .SUB_N      (SUB_N),
    .SUB_BASE   (SUB_BASE),
    .SUB_STRIDE (SUB_STRIDE)
  ) u_dec (
    .bar (cap_bar),
    .dwa (cap_dwa),
    .hit (ev_hit),
    .adr (dec_adr)
  );

  pwb_datapath #(
    .BAR_W (BAR_W),
    .DWA_W (DWA_W),
    .WB_AW (WB_AW),
    .DW    (DW),
    .TAG_W (TAG_W),
    .RID_W (RID_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_accept  (ev_accept),
    .ev_decode  (ev_decode),
    .ev_ack     (ev_ack),
    .req_is_wr  (req_is_wr),
    .req_bar    (req_bar),
    .req_dwa    (req_dwa),
    .req_be     (req_be),
    .req_tag    (req_tag),
    .req_rid    (req_rid),
    .req_data   (req_data),
    .dec_hit    (ev_hit),
    .dec_adr    (dec_adr),
    .wb_dat_i   (wb_dat_i),
    .cap_wr     (cap_wr),
    .cap_bar    (cap_bar),
    .cap_dwa    (cap_dwa),
    .cap_be     (wb_sel),
    .cap_tag    (cpl_tag),
    .cap_rid    (cpl_rid),
    .cap_data   (wb_dat_o),
    .adr_q      (wb_adr),
    .status_q   (cpl_status),
    .has_data_q (cpl_has_data),
    .rdata_q    (cpl_data)
  );

  assign in_cycle  = (state == ST_WB);
  assign req_ready = (state == ST_IDLE);
  assign wb_cyc    = in_cycle;
  assign wb_stb    = in_cycle;
  assign wb_we     = in_cycle && cap_wr;
  assign cpl_valid = (state == ST_CPL);

endmodule

// File: rtl/pwb_chk.sv
module pwb_chk #(
  parameter int WB_AW = 16,
  parameter int BE_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             wb_cyc,
  input logic             wb_stb,
  input logic             wb_we,
  input logic [WB_AW-1:0] wb_adr,
  input logic [BE_W-1:0]  wb_sel,
  input logic             wb_ack,
  input logic             cpl_valid,
  input logic [2:0]       cpl_status,
  input logic             cpl_has_data,
  input logic             ev_decode,
  input logic             ev_hit
);
  import pwb_pkg::*;

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> req_ready && !wb_cyc && !cpl_valid);

  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc || cpl_valid || ev_decode) |-> !req_ready);

  a_r2_accept_to_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ev_decode);

  a_r3_cycle_after_decode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_cyc) |-> $past(ev_decode && ev_hit));

  a_r6_miss_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_decode && !ev_hit) |=> !wb_cyc);

  a_r6_ur_without_data: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_status == CPL_UR) |-> !cpl_has_data);

  a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && !wb_ack) |=> wb_cyc && wb_stb && $stable(wb_adr) &&
                            $stable(wb_sel) && $stable(wb_we));

  a_r8_write_no_cpl: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && wb_ack && wb_we) |=> !cpl_valid && req_ready);

  a_r9_cpl_single: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |=> !cpl_valid && req_ready);

  a_r9_cpl_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpl_valid) |-> $past(wb_cyc && wb_ack && !wb_we) ||
                         $past(ev_decode && !ev_hit));

endmodule

bind pcie_wb_bridge pwb_chk #(.WB_AW(WB_AW), .BE_W(BE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .wb_cyc       (wb_cyc),
  .wb_stb       (wb_stb),
  .wb_we        (wb_we),
  .wb_adr       (wb_adr),
  .wb_sel       (wb_sel),
  .wb_ack       (wb_ack),
  .cpl_valid    (cpl_valid),
  .cpl_status   (cpl_status),
  .cpl_has_data (cpl_has_data),
  .ev_decode    (ev_decode),
  .ev_hit       (ev_hit)
);

// File: tb/pcie_wb_bridge_tb.sv
module pcie_wb_bridge_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_is_wr = 1'b0;
  logic [2:0]  req_bar = '0;
  logic [9:0]  req_dwa = '0;
  logic [3:0]  req_be = '0;
  logic [7:0]  req_tag = '0;
  logic [15:0] req_rid = '0;
  logic [31:0] req_data = '0;
  logic        wb_cyc, wb_stb, wb_we;
  logic [15:0] wb_adr;
  logic [3:0]  wb_sel;
  logic [31:0] wb_dat_o;
  logic [31:0] wb_dat_i = '0;
  logic        wb_ack = 1'b0;
  logic        cpl_valid, cpl_has_data;
  logic [2:0]  cpl_status;
  logic [31:0] cpl_data;
  logic [7:0]  cpl_tag;
  logic [15:0] cpl_rid;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pcie_wb_bridge u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_is_wr(req_is_wr),
    .req_bar(req_bar), .req_dwa(req_dwa), .req_be(req_be), .req_tag(req_tag),
    .req_rid(req_rid), .req_data(req_data),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_sel(wb_sel), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_ack(wb_ack),
    .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_has_data(cpl_has_data),
    .cpl_data(cpl_data), .cpl_tag(cpl_tag), .cpl_rid(cpl_rid)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected map, written from the requirements R4/R5/R6
  function automatic bit exp_hit(input logic [2:0] bar, input logic [9:0] d);
    if (bar == 3'd0) return 1'b1;
    if (bar == 3'd1) return (d / 64) < 3;
    return 1'b0;
  endfunction

  function automatic logic [15:0] exp_adr(input logic [2:0] bar, input logic [9:0] d);
    int unsigned a;
    if (bar == 3'd0) a = 4 * int'(d);
    else             a = 32'h4000 + (int'(d) / 64) * 32'h1000 + (int'(d) % 64) * 4;
    return a[15:0];
  endfunction

  task automatic txn(input bit wr, input logic [2:0] bar, input logic [9:0] d,
                     input logic [3:0] be, input logic [7:0] tag,
                     input logic [15:0] rid, input logic [31:0] wd,
                     input logic [31:0] rd, input int dly);
    bit hit;
    int cyc_first, ack_cnt, done_cnt, cpl_cnt, n_cpl, waitc;
    bit ack_done, moved;
    logic [2:0]  c_st;
    logic        c_hd;
    logic [31:0] c_dat;
    logic [7:0]  c_tag;
    logic [15:0] c_rid;
    hit = exp_hit(bar, d);
    cyc_first = -1; ack_cnt = -1; done_cnt = -1; cpl_cnt = -1; n_cpl = 0;
    waitc = 0; ack_done = 0; moved = 0;
    c_st = '0; c_hd = 0; c_dat = '0; c_tag = '0; c_rid = '0;
    req_valid = 1; req_is_wr = wr; req_bar = bar; req_dwa = d; req_be = be;
    req_tag = tag; req_rid = rid; req_data = wd;
    @(negedge clk);
    req_valid = 0;
    for (int cnt = 1; cnt <= 80; cnt++) begin
      if (cnt == 1) chk(req_ready == 1'b0, "R2 ready low after accept", req_ready, 0);
      if (wb_cyc) begin
        if (cyc_first < 0) begin
          cyc_first = cnt;
          chk(wb_stb == 1'b1, "R7 stb with cyc", wb_stb, 1);
          chk(wb_adr == exp_adr(bar, d), bar == 0 ? "R4 address" : "R5 address",
              wb_adr, exp_adr(bar, d));
          chk(wb_we == wr, "R7 we", wb_we, wr);
          chk(wb_sel == be, "R7 sel", wb_sel, be);
          if (wr) chk(wb_dat_o == wd, "R7 write data", wb_dat_o, wd);
        end else if (wb_adr != exp_adr(bar, d) || wb_sel != be || wb_we != wr) begin
          moved = 1;
        end
      end
      if (cpl_valid) begin
        n_cpl++; cpl_cnt = cnt; c_st = cpl_status; c_hd = cpl_has_data;
        c_dat = cpl_data; c_tag = cpl_tag; c_rid = cpl_rid;
      end
      if (wb_ack) wb_ack = 0;
      else if (wb_cyc && !ack_done) begin
        if (waitc >= dly) begin
          wb_ack = 1; wb_dat_i = rd; ack_done = 1; ack_cnt = cnt;
        end else waitc++;
      end
      if (req_ready && cnt > 1) begin
        done_cnt = cnt;
        break;
      end
      @(negedge clk);
    end
    wb_ack = 0;
    if (hit) begin
      chk(cyc_first == 2, "R3 cycle start", cyc_first, 2);
      chk(!moved, "R7 held until ack", moved, 0);
      if (wr) begin
        chk(n_cpl == 0, "R8 no completion for write", n_cpl, 0);
        chk(done_cnt == ack_cnt + 1, "R8 ready after ack", done_cnt, ack_cnt + 1);
      end else begin
        chk(n_cpl == 1 && cpl_cnt == ack_cnt + 1, "R9 completion timing",
            cpl_cnt, ack_cnt + 1);
        chk(c_st == 3'b000 && c_hd == 1'b1, "R9 status/has_data", {c_st, c_hd}, 4'b0001);
        chk(c_dat == rd, "R9 data", c_dat, rd);
        chk(c_tag == tag && c_rid == rid, "R9 tag/rid", {c_tag, c_rid}, {tag, rid});
        chk(done_cnt == ack_cnt + 2, "R9 ready return", done_cnt, ack_cnt + 2);
      end
    end else begin
      chk(cyc_first < 0, "R6 no bus cycle on miss", cyc_first, -1);
      if (wr) begin
        chk(n_cpl == 0, "R6 write dropped", n_cpl, 0);
        chk(done_cnt == 2, "R6 ready after decode", done_cnt, 2);
      end else begin
        chk(n_cpl == 1 && cpl_cnt == 2, "R10 miss completion timing", cpl_cnt, 2);
        chk(c_st == 3'b001 && c_hd == 1'b0 && c_dat == 0, "R6 UR completion",
            {c_st, c_hd, c_dat}, {3'b001, 1'b0, 32'h0});
        chk(c_tag == tag && c_rid == rid, "R6 tag/rid echo", {c_tag, c_rid}, {tag, rid});
        chk(done_cnt == 3, "R10 ready return", done_cnt, 3);
      end
    end
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && wb_cyc == 0 && cpl_valid == 0, "R1 state in reset",
        {req_ready, wb_cyc, cpl_valid}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && wb_cyc == 0 && wb_stb == 0 && cpl_valid == 0,
        "R1 state after reset", {req_ready, wb_cyc, wb_stb, cpl_valid}, 4'b1000);
    // directed corners
    txn(0, 3'd0, 10'h3FF, 4'hF, 8'h11, 16'h0102, 32'h0, 32'hCAFE_F00D, 0);
    txn(1, 3'd0, 10'h000, 4'h1, 8'h12, 16'h0203, 32'h1234_5678, 32'h0, 3);
    txn(0, 3'd1, 10'd191, 4'hC, 8'h13, 16'h0304, 32'h0, 32'hA5A5_5A5A, 1);
    txn(0, 3'd1, 10'd192, 4'hF, 8'h14, 16'h0405, 32'h0, 32'h0, 0);
    txn(1, 3'd1, 10'h3FF, 4'hF, 8'h15, 16'h0506, 32'hDEAD_BEEF, 32'h0, 0);
    txn(0, 3'd5, 10'h001, 4'hF, 8'h16, 16'h0607, 32'h0, 32'h0, 0);
    txn(1, 3'd1, 10'd64, 4'h6, 8'h17, 16'h0708, 32'h0BAD_0BAD, 32'h0, 2);
    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [2:0] b;
      logic [9:0] d;
      b = ($urandom % 4 == 0) ? 3'($urandom % 8) : 3'($urandom % 2);
      d = ($urandom % 2) ? 10'($urandom) : 10'($urandom % 192);
      txn(1'($urandom), b, d, 4'($urandom), 8'($urandom), 16'($urandom),
          $urandom, $urandom, int'($urandom % 5));
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule